// File: doc/BRIEF.md
# Multiplexed CPU Bus Cycle Sequencer

This block produces the external pin timing of an 8-bit processor with a 16-bit address space. A core hands it one machine cycle at a time: a cycle kind, an address and, for writes, a data byte. The sequencer then steps through the T-states of that cycle. It drives the address, the strobes and the write data, stretches the cycle while the slow-device input asks it to, and returns the byte it read. It also flags the final T-state so the core can present the next cycle without a gap.

An opcode fetch uses its last two T-states to refresh dynamic memory. In those states the address bus carries a page byte and a refresh byte, and the low seven bits of the refresh byte advance once per fetch. I/O cycles switch the space strobe and add one automatic wait state. When an external master asks for the bus, the sequencer finishes the current cycle first, then floats the address, data and bus strobes and acknowledges the request until it is withdrawn.

Requests use a valid/ready handshake. The core holds `req_valid` and its fields steady until it sees `req_ready` high at a clock edge. `req_ready` is high only when the sequencer is idle or in the final T-state of a cycle, and only while no bus request is pending. A pending bus request therefore back-pressures the core for as long as the bus is granted away. Read data and the done strobe carry no handshake: `rd_data` holds the last captured byte until the next read captures a new one.

Top module: `bus_cycle_seq`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the sequencer is idle or in its final T-state, with `busreq_n` high, and not in the first clock after reset. The cycle's T1 begins on that edge. `req_kind` encodes 2'b00 opcode fetch, 2'b01 memory read, 2'b10 memory write and 2'b11 I/O. For I/O, `req_io_wr`=1 selects a write.
- R2: In an opcode fetch, during T1, T2 and any wait states, `addr_o` equals the requested address and `mreq_n`, `rd_n` and `m1_n` are low. `data_i` is captured into `rd_data` on the edge that starts T3.
- R3: During T3 and T4 of an opcode fetch, `mreq_n` and `rfsh_n` are low and `rd_n` and `m1_n` are high. `addr_o` is {page[7:0], refresh[7:0]}, with refresh bits 6:0 forming the counter.
- R4: After every opcode fetch, refresh bits 6:0 advance by one modulo 128 and bit 7 keeps its value. `ld_rfsh` loads `ld_value` into the whole refresh byte and `ld_page` loads it into the page byte. A load in the same clock as the increment wins.
- R5: A memory read with no waits lasts exactly T1, T2 and T3. `mreq_n` and `rd_n` are low throughout, and `data_i` is captured on the edge that starts T3.
- R6: In a memory write, `data_oe` is high and `data_o` equals the write byte from T1 through T3. `wr_n` is low in T2 and in wait states and high in T3, while `addr_o` and `data_o` keep their values.
- R7: An I/O cycle drives `iorq_n` low from T2 through T3 and never asserts `mreq_n`. It always passes through one automatic wait state after T2, during which `wait_n` is not examined. `rd_n` is low from T2 through T3 for a read, and `wr_n` is low from T2 up to T3 for a write. Read data is captured on the edge that starts T3.
- R8: `wait_n` is sampled at the end of T2 (fetch and memory cycles), at the end of the automatic wait (I/O) and at the end of every wait state. While it is sampled low, another wait state follows. `wait_n` has no effect in any other T-state.
- R9: `cyc_done` is high for exactly one clock: during T4 of a fetch and during T3 of every other cycle.
- R10: `busreq_n` is sampled at the end of the final T-state and on every idle clock. When it is low, the next clock floats the bus (`addr_oe`, `ctrl_oe` and `data_oe` low) and drives `busack_n` low. No request is accepted until `busreq_n` returns high, after which the sequencer is idle.
- R11: While `rst_n` is low, `addr_oe`, `ctrl_oe` and `data_oe` are low, all strobes and `busack_n` are high, and the refresh and page bytes are cleared.
- R12: `data_oe` is high only during memory write and I/O write cycles, never while `busack_n` is low, and never together with a low `rd_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per T-state |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Cycle request present |
| req_ready | output | 1 | Sequencer can take a request this clock |
| req_kind | input | 2 | Cycle kind (fetch, memory read, memory write, I/O) |
| req_io_wr | input | 1 | Direction of an I/O cycle, 1 = write |
| req_addr | input | 16 | Address of the requested cycle |
| req_wdata | input | 8 | Byte to write |
| ld_rfsh | input | 1 | Load `ld_value` into the refresh byte |
| ld_page | input | 1 | Load `ld_value` into the page byte |
| ld_value | input | 8 | Value for the refresh or page load |
| wait_n | input | 1 | Slow-device request for wait states, active low |
| busreq_n | input | 1 | External master asks for the bus, active low |
| data_i | input | 8 | Data bus as seen at the pins |
| addr_o | output | 16 | Address bus value |
| addr_oe | output | 1 | Address bus drive enable |
| data_o | output | 8 | Data bus value during writes |
| data_oe | output | 1 | Data bus drive enable |
| ctrl_oe | output | 1 | Drive enable for the memory, I/O, read and write strobes |
| mreq_n | output | 1 | Memory space strobe, active low |
| iorq_n | output | 1 | I/O space strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m1_n | output | 1 | Opcode fetch marker, active low |
| rfsh_n | output | 1 | Refresh slot marker, active low |
| busack_n | output | 1 | Bus granted to the external master, active low |
| rd_data | output | 8 | Last byte captured by a read or fetch |
| cyc_done | output | 1 | Final T-state of the current cycle |

## Verification
All four cycle kinds are issued in random order with zero to three requested waits, so the T-state count of each kind can be told apart from the stretch added by `wait_n`. In states where `wait_n` is not sampled, it is driven to random values, and `data_i` carries the expected byte only in the clock before T3. A wrong sampling point or capture edge therefore shows up as a changed cycle length or a wrong `rd_data`. The refresh byte is loaded to values just below the 7-bit wrap, and also loaded in the same clock as a fetch increment, which separates a correct carry-free increment and load priority from a plain 8-bit count. Bus requests are raised both while idle and in the middle of a cycle, to show that the cycle always completes before the bus floats and that requests are held off during the grant.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    K_FETCH = 2'b00,
    K_MRD   = 2'b01,
    K_MWR   = 2'b10,
    K_IO    = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_T1,
    S_T2,
    S_TWA,
    S_TW,
    S_T3,
    S_T4,
    S_GRANT
  } tstate_e;
endpackage

// File: rtl/bcs_refresh.sv
module bcs_refresh #(
  parameter int DATA_W = 8,
  parameter int RCNT_W = 7,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              ld_rfsh,
  input  logic              ld_page,
  input  logic [DATA_W-1:0] ld_value,
  output logic [DATA_W-1:0] rfsh_q,
  output logic [PAGE_W-1:0] page_q
);
  localparam int TOP_W = DATA_W - RCNT_W;

  logic [RCNT_W-1:0] cnt_nxt;
  assign cnt_nxt = rfsh_q[RCNT_W-1:0] + RCNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfsh_q <= '0;
    end else if (ld_rfsh) begin
      rfsh_q <= ld_value;
    end else if (inc) begin
      rfsh_q <= {rfsh_q[DATA_W-1:RCNT_W], cnt_nxt};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (ld_page) begin
      page_q <= PAGE_W'(ld_value);
    end
  end

  AST_RFSH_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_rfsh) |=> (rfsh_q[DATA_W-1:RCNT_W] == $past(rfsh_q[DATA_W-1:RCNT_W]))); // R4

  AST_RFSH_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rfsh |=> (rfsh_q == $past(ld_value))); // R4

  logic [TOP_W-1:0] top_unused_chk;
  assign top_unused_chk = rfsh_q[DATA_W-1:RCNT_W];
endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int IO_WAITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  kind_e             req_kind,
  input  logic              req_io_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              wait_n,
  input  logic              busreq_n,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_ready,
  output tstate_e           state,
  output kind_e             kind,
  output logic              io_wr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              cyc_done,
  output logic              rfsh_inc,
  output logic              live
);
  localparam int WCNT_W = (IO_WAITS > 1) ? $clog2(IO_WAITS) : 1;

  tstate_e           nxt;
  logic [WCNT_W-1:0] wcnt;
  logic              last, accept, is_read;

  assign last      = (state == S_T4) || (state == S_T3 && kind != K_FETCH);
  assign req_ready = live && busreq_n && (state == S_IDLE || last);
  assign accept    = req_valid && req_ready;
  assign cyc_done  = last;
  assign rfsh_inc  = (state == S_T4);
  assign is_read   = (kind == K_FETCH) || (kind == K_MRD) || (kind == K_IO && !io_wr);

  always_comb begin
    nxt = state;
    if (state == S_IDLE || last) begin
      if (!busreq_n)   nxt = S_GRANT;
      else if (accept) nxt = S_T1;
      else             nxt = S_IDLE;
    end else begin
      case (state)
        S_T1:    nxt = S_T2;
        S_T2:    nxt = (kind == K_IO) ? S_TWA : (wait_n ? S_T3 : S_TW);
        S_TWA:   nxt = (wcnt != '0) ? S_TWA : (wait_n ? S_T3 : S_TW);
        S_TW:    nxt = wait_n ? S_T3 : S_TW;
        S_T3:    nxt = S_T4;
        S_GRANT: nxt = busreq_n ? S_IDLE : S_GRANT;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      kind      <= K_FETCH;
      io_wr     <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      rd_data   <= '0;
      wcnt      <= '0;
      live      <= 1'b0;
    end else begin
      live  <= 1'b1;
      state <= nxt;
      if (accept) begin
        kind      <= req_kind;
        io_wr     <= req_io_wr;
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
      end
      if (state == S_T2 && kind == K_IO) begin
        wcnt <= WCNT_W'(IO_WAITS - 1);
      end else if (state == S_TWA && wcnt != '0) begin
        wcnt <= wcnt - WCNT_W'(1);
      end
      if (nxt == S_T3 && is_read) begin
        rd_data <= data_i;
      end
    end
  end

  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_T1) |-> $past(req_valid)); // R1

  AST_IO_AUTO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_T2 && kind == K_IO) |=> (state == S_TWA)); // R7

  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TW && !wait_n) |=> (state == S_TW)); // R8

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GRANT && !busreq_n) |=> (state == S_GRANT)); // R10
endmodule

// File: rtl/bcs_pins.sv
module bcs_pins
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8
) (
  input  tstate_e           state,
  input  kind_e             kind,
  input  logic              io_wr,
  input  logic              live,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic [DATA_W-1:0] rfsh_q,
  input  logic [PAGE_W-1:0] page_q,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              ctrl_oe,
  output logic              mreq_n,
  output logic              iorq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m1_n,
  output logic              rfsh_n,
  output logic              busack_n
);
  logic in_cyc, early, mid, bus_live, rfsh_slot;
  logic is_fetch, is_io, io_rd, io_w;

  assign in_cyc    = state inside {S_T1, S_T2, S_TWA, S_TW, S_T3, S_T4};
  assign early     = state inside {S_T1, S_T2, S_TW};
  assign mid       = state inside {S_T2, S_TWA, S_TW};
  assign bus_live  = live && (state != S_GRANT);
  assign is_fetch  = (kind == K_FETCH);
  assign is_io     = (kind == K_IO);
  assign io_rd     = is_io && !io_wr;
  assign io_w      = is_io && io_wr;
  assign rfsh_slot = is_fetch && (state inside {S_T3, S_T4});

  assign addr_o   = rfsh_slot ? {page_q, rfsh_q} : cur_addr;
  assign addr_oe  = bus_live;
  assign ctrl_oe  = bus_live;
  assign data_o   = cur_wdata;
  assign data_oe  = bus_live && in_cyc && ((kind == K_MWR) || io_w);

  assign mreq_n   = !(in_cyc && !is_io);
  assign iorq_n   = !(is_io && (mid || state == S_T3));
  assign rd_n     = !((is_fetch && early) ||
                      (kind == K_MRD && (early || state == S_T3)) ||
                      (io_rd && (mid || state == S_T3)));
  assign wr_n     = !((kind == K_MWR && (state inside {S_T2, S_TW})) || (io_w && mid));
  assign m1_n     = !(is_fetch && early);
  assign rfsh_n   = !rfsh_slot;
  assign busack_n = (state != S_GRANT);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int RCNT_W   = 7,
  parameter int IO_WAITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_io_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ld_rfsh,
  input  logic              ld_page,
  input  logic [DATA_W-1:0] ld_value,
  input  logic              wait_n,
  input  logic              busreq_n,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              ctrl_oe,
  output logic              mreq_n,
  output logic              iorq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m1_n,
  output logic              rfsh_n,
  output logic              busack_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              cyc_done
);
  localparam int PAGE_W = ADDR_W - DATA_W;

  tstate_e           state;
  kind_e             kind;
  logic              io_wr, live, rfsh_inc;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata, rfsh_q;
  logic [PAGE_W-1:0] page_q;

  bcs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_WAITS(IO_WAITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(kind_e'(req_kind)),
    .req_io_wr(req_io_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .wait_n(wait_n), .busreq_n(busreq_n), .data_i(data_i), .req_ready(req_ready),
    .state(state), .kind(kind), .io_wr(io_wr), .cur_addr(cur_addr),
    .cur_wdata(cur_wdata), .rd_data(rd_data), .cyc_done(cyc_done),
    .rfsh_inc(rfsh_inc), .live(live)
  );

  bcs_refresh #(.DATA_W(DATA_W), .RCNT_W(RCNT_W), .PAGE_W(PAGE_W)) u_rfsh (
    .clk(clk), .rst_n(rst_n), .inc(rfsh_inc), .ld_rfsh(ld_rfsh), .ld_page(ld_page),
    .ld_value(ld_value), .rfsh_q(rfsh_q), .page_q(page_q)
  );

  bcs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_pins (
    .state(state), .kind(kind), .io_wr(io_wr), .live(live), .cur_addr(cur_addr),
    .cur_wdata(cur_wdata), .rfsh_q(rfsh_q), .page_q(page_q), .addr_o(addr_o),
    .addr_oe(addr_oe), .data_o(data_o), .data_oe(data_oe), .ctrl_oe(ctrl_oe),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
    .rfsh_n(rfsh_n), .busack_n(busack_n)
  );

  AST_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> ($stable(addr_o) && $stable(data_o))); // R6

  AST_FLOAT_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !busack_n |-> (!addr_oe && !ctrl_oe && !data_oe)); // R10

  AST_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~mreq_n, ~iorq_n})); // R7

  AST_DOE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (rd_n && busack_n)); // R12

  always_comb begin
    if (!rst_n) begin
      AST_RESET_FLOAT: assert (!addr_oe && !ctrl_oe && !data_oe && busack_n); // R11
    end
  end
endmodule

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;
  localparam int ST_T1 = 1, ST_T2 = 2, ST_TWA = 3, ST_TW = 4, ST_T3 = 5, ST_T4 = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_io_wr = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ld_value = '0, data_i = '0;
  logic        ld_rfsh = 1'b0, ld_page = 1'b0, wait_n = 1'b1, busreq_n = 1'b1;
  logic        req_ready, addr_oe, data_oe, ctrl_oe, cyc_done;
  logic        mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, busack_n;
  logic [15:0] addr_o;
  logic [7:0]  data_o, rd_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] rm = 8'h00, pm = 8'h00;

  always #4 clk = ~clk;

  bus_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_io_wr(req_io_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ld_rfsh(ld_rfsh), .ld_page(ld_page), .ld_value(ld_value),
    .wait_n(wait_n), .busreq_n(busreq_n), .data_i(data_i), .addr_o(addr_o),
    .addr_oe(addr_oe), .data_o(data_o), .data_oe(data_oe), .ctrl_oe(ctrl_oe),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
    .rfsh_n(rfsh_n), .busack_n(busack_n), .rd_data(rd_data), .cyc_done(cyc_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // expected strobes {mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}
  function automatic logic [5:0] exp_ctl(input logic [1:0] k, input bit iw, input int st);
    bit early = (st == ST_T1) || (st == ST_T2) || (st == ST_TW);
    bit mid   = (st == ST_T2) || (st == ST_TWA) || (st == ST_TW);
    bit io    = (k == 2'b11);
    bit mq = 0, iq = 0, rd = 0, wr = 0, m1 = 0, rf = 0;
    case (k)
      2'b00: begin mq = 1; rd = early; m1 = early; rf = (st == ST_T3) || (st == ST_T4); end
      2'b01: begin mq = 1; rd = early || (st == ST_T3); end
      2'b10: begin mq = 1; wr = (st == ST_T2) || (st == ST_TW); end
      default: begin
        iq = mid || (st == ST_T3);
        if (iw) wr = mid; else rd = mid || (st == ST_T3);
      end
    endcase
    if (io) mq = 0;
    return ~{mq, iq, rd, wr, m1, rf};
  endfunction

  task automatic check_idle(input string req);
    chk({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, busack_n} == 7'h7F, req,
        {mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, busack_n}, 7'h7F);
    chk(addr_oe && ctrl_oe && !data_oe && !cyc_done, req,
        {addr_oe, ctrl_oe, data_oe, cyc_done}, 4'b1100);
  endtask

  task automatic run_cyc(input logic [1:0] k, input bit iw, input logic [15:0] a,
                         input logic [7:0] wd, input logic [7:0] rv, input int nw,
                         input bit breq_mid, input bit ld_last, input logic [7:0] ldv);
    int seq[16];
    int len = 0;
    bit is_wr = (k == 2'b10) || (k == 2'b11 && iw);
    seq[len++] = ST_T1;
    seq[len++] = ST_T2;
    if (k == 2'b11) seq[len++] = ST_TWA;
    for (int w = 0; w < nw; w++) seq[len++] = ST_TW;
    seq[len++] = ST_T3;
    if (k == 2'b00) seq[len++] = ST_T4;

    chk(req_ready == 1'b1, "R1 ready when idle", {31'd0, req_ready}, 1);
    req_valid = 1'b1; req_kind = k; req_io_wr = iw; req_addr = a; req_wdata = wd;
    for (int i = 0; i < len; i++) begin
      int st = seq[i];
      int nx = (i + 1 < len) ? seq[i + 1] : 0;
      bit samp = (st == ST_T2 && k != 2'b11) || (st == ST_TWA) || (st == ST_TW);
      logic [15:0] ea;
      @(negedge clk);
      if (i == 0) begin
        req_valid = 1'b0;
        req_addr = 16'($urandom); req_wdata = 8'($urandom);
        req_kind = 2'($urandom); req_io_wr = 1'($urandom);
      end
      wait_n = samp ? (nx != ST_TW) : 1'($urandom);
      data_i = (nx == ST_T3) ? rv : 8'($urandom);
      if (breq_mid && i == 1) busreq_n = 1'b0;
      if (ld_last && i == len - 1) begin ld_rfsh = 1'b1; ld_value = ldv; end
      ea = (k == 2'b00 && (st == ST_T3 || st == ST_T4)) ? {pm, rm} : a;
      chk({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n} == exp_ctl(k, iw, st),
          "R2 R3 R5 R6 R7 strobes", {mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}, exp_ctl(k, iw, st));
      chk(addr_o == ea, "R2 R3 address", addr_o, ea);
      chk(addr_oe && ctrl_oe && busack_n, "R10 bus driven in cycle", {addr_oe, ctrl_oe, busack_n}, 3'b111);
      chk(data_oe == is_wr, "R12 data enable", data_oe, is_wr);
      if (is_wr) chk(data_o == wd, "R6 write data", data_o, wd);
      chk(cyc_done == (i == len - 1), "R9 done strobe", cyc_done, (i == len - 1));
      if (i == len - 1) begin
        if (!is_wr) chk(rd_data == rv, "R5 R7 R2 captured read", rd_data, rv);
        chk(req_ready == !breq_mid, "R1 R10 ready at done", req_ready, !breq_mid);
      end
    end
    if (k == 2'b00) rm = {rm[7], rm[6:0] + 7'd1};
    if (ld_last) rm = ldv;
    @(negedge clk);
    ld_rfsh = 1'b0; wait_n = 1'b1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!addr_oe && !ctrl_oe && !data_oe, "R11 floated in reset", {addr_oe, ctrl_oe, data_oe}, 0);
    chk({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, busack_n} == 7'h7F, "R11 strobes idle in reset",
        {mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, busack_n}, 7'h7F);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R11 idle after reset");

    // R3 R11: cleared page and refresh seen on first fetch
    run_cyc(2'b00, 0, 16'h1234, 8'h00, 8'h3E, 0, 0, 0, 8'h00);
    check_idle("R1 idle between cycles");

    // R4: load page and refresh near wrap
    ld_page = 1'b1; ld_value = 8'hA5; @(negedge clk); ld_page = 1'b0; pm = 8'hA5;
    ld_rfsh = 1'b1; ld_value = 8'hFF; @(negedge clk); ld_rfsh = 1'b0; rm = 8'hFF;
    run_cyc(2'b00, 0, 16'h0100, 8'h00, 8'h11, 1, 0, 0, 8'h00);
    ld_rfsh = 1'b1; ld_value = 8'h7F; @(negedge clk); ld_rfsh = 1'b0; rm = 8'h7F;
    run_cyc(2'b00, 0, 16'h0101, 8'h00, 8'h22, 0, 0, 0, 8'h00);
    run_cyc(2'b00, 0, 16'h0102, 8'h00, 8'h23, 0, 0, 0, 8'h00);
    // R4: load in same clock as increment wins
    run_cyc(2'b00, 0, 16'h0103, 8'h00, 8'h24, 0, 0, 1, 8'h3C);
    run_cyc(2'b00, 0, 16'h0104, 8'h00, 8'h25, 0, 0, 0, 8'h00);

    // R5 R6 R7 R8 directed
    run_cyc(2'b01, 0, 16'hBEEF, 8'h00, 8'h5A, 0, 0, 0, 8'h00);
    run_cyc(2'b10, 0, 16'hC001, 8'h96, 8'h00, 0, 0, 0, 8'h00);
    run_cyc(2'b10, 0, 16'hC002, 8'h69, 8'h00, 3, 0, 0, 8'h00);
    run_cyc(2'b11, 0, 16'h00FE, 8'h00, 8'hC3, 0, 0, 0, 8'h00);
    run_cyc(2'b11, 1, 16'h00FD, 8'h81, 8'h00, 2, 0, 0, 8'h00);

    // R10: bus request while idle, request held off
    busreq_n = 1'b0; req_valid = 1'b1; req_kind = 2'b01;
    @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      chk(!busack_n && !addr_oe && !ctrl_oe && !data_oe, "R10 grant floats bus",
          {busack_n, addr_oe, ctrl_oe, data_oe}, 0);
      chk(!req_ready && mreq_n && rd_n, "R10 no accept in grant", {req_ready, mreq_n, rd_n}, 3'b011);
      @(negedge clk);
    end
    busreq_n = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    check_idle("R10 idle after release");

    // R10: bus request in mid-cycle completes the cycle first
    run_cyc(2'b01, 0, 16'h4444, 8'h00, 8'h77, 1, 1, 0, 8'h00);
    chk(!busack_n && !addr_oe, "R10 grant after cycle", {busack_n, addr_oe}, 0);
    busreq_n = 1'b1;
    @(negedge clk);
    check_idle("R10 idle after mid-cycle grant");

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [1:0] k = 2'($urandom);
      run_cyc(k, 1'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
              int'($urandom % 4), 0, 0, 8'h00);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule